// File: doc/BRIEF.md
# Tamper Detect and Memory Clear Controller

This block guards one tamper switch. The switch level passes through a short synchronizer and is then checked either on every clock cycle or only on a 1 Hz strobe. A configuration bit selects the switch polarity. When the armed channel sees its tamper level, the block sets a sticky tamper flag. It raises a reset request for a fixed number of system clock cycles. Depending on configuration, it also zeroes an internal 128-byte user memory and drives a timed external clear pulse.

Software reaches the user memory through a request stream with valid/ready handshaking. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The block lowers `req_ready` while it is zeroing the memory, so the requester must hold the request until it is accepted. A read answer appears on `rsp_valid`/`rsp_data` for one cycle, on the cycle after acceptance. The answer has no back-pressure, and the requester must capture it in that cycle. Once a tamper event has zeroed the memory, the memory stays locked until software disarms the channel. While it is locked, reads return a fixed invalid byte and writes are dropped.

Top module: `tamper_guard`

## Requirements
- R1: After reset, `tamper_flag`, `ram_locked`, `clear_busy`, `rst_req`, `ext_clr` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: With `polarity_open`=0 the tamper level on `tamper_in` is 1; with `polarity_open`=1 it is 0. The opposite level never raises `tamper_flag`, and `tamper_flag` is 0 while `arm` is 0.
- R3: In continuous monitoring, a tamper level on `tamper_in` sets `tamper_flag` on the third rising clock edge after the change. The flag stays set while `arm` stays 1, even after the pin returns to its idle level.
- R4: With `sample_1hz`=1, `polarity_open`=0 and `osc_run`=1, a tamper level is acted on only in a cycle where `tick_1hz` is 1.
- R5: With `osc_run`=0, `sample_1hz` is ignored and monitoring is continuous.
- R6: With `polarity_open`=1, `sample_1hz` is ignored and monitoring is continuous.
- R7: On an event with `clr_ram`=1, all 128 bytes are written to 0x00 one per cycle. `clear_busy` is high for exactly 128 cycles, and `req_ready` is 0 throughout.
- R8: After such an event, `ram_locked` is 1 until `arm` is written to 0. While it is locked, reads return 0xFF and writes are dropped.
- R9: An event with `clr_ram`=0 neither zeroes nor locks the memory.
- R10: Each event drives `rst_req` high for exactly RST_CYCLES consecutive cycles. It starts on the same edge that sets `tamper_flag`.
- R11: `ext_clr` rises on the event edge only when `clr_ext`=1. It falls on the N-th `tick_1hz` cycle after that, where N is 1, 2, 4 or 8 for `clr_width` codes 0, 1, 2 and 3.
- R12: A read accepted on an edge yields `rsp_valid`=1 with the stored byte in the following cycle. A write accepted while unlocked updates that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_in | input | 1 | Tamper switch level (asynchronous) |
| tick_1hz | input | 1 | One-cycle 1 Hz strobe |
| osc_run | input | 1 | Oscillator running flag |
| arm | input | 1 | Channel enable; 0 re-arms and unlocks |
| polarity_open | input | 1 | 1 = normally-open switch, 0 = normally-closed |
| sample_1hz | input | 1 | Check the pin only on ticks (normally-closed only) |
| clr_ram | input | 1 | Zero and lock user memory on event |
| clr_ext | input | 1 | Drive external clear pulse on event |
| clr_width | input | 2 | External clear length code (1/2/4/8 ticks) |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 8 | Read data |
| tamper_flag | output | 1 | Sticky tamper flag |
| ram_locked | output | 1 | User memory locked |
| clear_busy | output | 1 | Memory zeroing in progress |
| rst_req | output | 1 | Reset request |
| ext_clr | output | 1 | External clear pulse |

## Verification
The bench targets the polarity and mode-selection corners. These are sampling with no strobe, sampling with the oscillator stopped, and sampling requested in normally-open mode. A design that applied the sampling setting in those last two cases would miss an event, and one that ignored it would fire without a strobe. It counts the exact length of the zeroing window and of the reset pulse. An off-by-one counter would leave the last memory byte intact or stretch the reset. It reads the locked memory before and after disarming and writes into it while locked. A design that leaked stored data, accepted the write, or unlocked early would return a non-0xFF or non-zero byte. It also checks the external pulse for the shortest and a longer width code, and checks that the pulse stays low when it is disabled.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef struct packed {
    logic       en;
    logic       open_pol;
    logic       sample;
    logic       zap_ram;
    logic       zap_ext;
    logic [1:0] width;
  } tg_cfg_t;

endpackage

// File: rtl/tg_detect.sv
module tg_detect
  import tg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tamper_in,
  input  logic    tick,
  input  logic    osc_run,
  input  tg_cfg_t cfg,
  output logic    flag,
  output logic    hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, at_tamper, use_sample, strobe;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= tamper_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], tamper_in};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    at_tamper  = cfg.open_pol ? !pin_s : pin_s;
    use_sample = cfg.sample && !cfg.open_pol && osc_run;
    strobe     = !use_sample || tick;
    hit        = cfg.en && at_tamper && strobe && !flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (!cfg.en) flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
  end

endmodule

// File: rtl/tg_ramctl.sv
module tg_ramctl #(
  parameter int          DEPTH   = 128,
  parameter int          DW      = 8,
  parameter logic [DW-1:0] INVALID = '1,
  localparam int         AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_clear,
  input  logic          release_lock,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          locked
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wipe_addr;
  logic          take, take_wr;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign take_wr   = take && req_write && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wipe_addr <= '0;
    end else if (start_clear) begin
      busy      <= 1'b1;
      wipe_addr <= '0;
    end else if (busy) begin
      if (wipe_addr == LAST) busy <= 1'b0;
      wipe_addr <= wipe_addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            locked <= 1'b0;
    else if (start_clear)  locked <= 1'b1;
    else if (release_lock) locked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (busy)         mem[wipe_addr] <= '0;
    else if (take_wr) mem[req_addr]  <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= take && !req_write;
      if (take && !req_write) rsp_data <= locked ? INVALID : mem[req_addr];
    end
  end

endmodule

// File: rtl/tg_pulse.sv
module tg_pulse #(
  parameter int RST_CYCLES = 1000,
  parameter int CODE_W     = 2,
  localparam int RW        = $clog2(RST_CYCLES + 1),
  localparam int TW        = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_ext,
  input  logic [CODE_W-1:0] width_code,
  input  logic              tick,
  output logic              rst_req,
  output logic              ext_clr
);

  logic [RW-1:0]     rst_cnt;
  logic [TW-1:0]     tick_cnt;
  logic [TW-1:0]     tick_last;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rst_cnt <= '0;
    else if (start)        rst_cnt <= RW'(RST_CYCLES);
    else if (rst_cnt != 0) rst_cnt <= rst_cnt - 1'b1;
  end

  assign rst_req   = (rst_cnt != 0);
  assign tick_last = TW'((1 << code_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_clr  <= 1'b0;
      tick_cnt <= '0;
      code_q   <= '0;
    end else if (start_ext) begin
      ext_clr  <= 1'b1;
      tick_cnt <= '0;
      code_q   <= width_code;
    end else if (ext_clr && tick) begin
      if (tick_cnt == tick_last) ext_clr <= 1'b0;
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tg_pkg::*;
#(
  parameter int          DEPTH       = 128,
  parameter int          DW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_CYCLES  = 1000,
  parameter logic [DW-1:0] INVALID   = '1,
  localparam int         AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tamper_in,
  input  logic          tick_1hz,
  input  logic          osc_run,
  input  logic          arm,
  input  logic          polarity_open,
  input  logic          sample_1hz,
  input  logic          clr_ram,
  input  logic          clr_ext,
  input  logic [1:0]    clr_width,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          tamper_flag,
  output logic          ram_locked,
  output logic          clear_busy,
  output logic          rst_req,
  output logic          ext_clr
);

  tg_cfg_t cfg;
  logic    hit;

  assign cfg = '{en: arm, open_pol: polarity_open, sample: sample_1hz,
                 zap_ram: clr_ram, zap_ext: clr_ext, width: clr_width};

  tg_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in), .tick(tick_1hz),
    .osc_run(osc_run), .cfg(cfg), .flag(tamper_flag), .hit(hit)
  );

  tg_ramctl #(.DEPTH(DEPTH), .DW(DW), .INVALID(INVALID)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .start_clear(hit && cfg.zap_ram), .release_lock(!cfg.en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(clear_busy), .locked(ram_locked)
  );

  tg_pulse #(.RST_CYCLES(RST_CYCLES), .CODE_W(2)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(hit), .start_ext(hit && cfg.zap_ext),
    .width_code(cfg.width), .tick(tick_1hz),
    .rst_req(rst_req), .ext_clr(ext_clr)
  );

endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk #(
  parameter int          DW      = 8,
  parameter int          AW      = 7,
  parameter logic [DW-1:0] INVALID = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          clr_ext,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          tamper_flag,
  input logic          ram_locked,
  input logic          clear_busy,
  input logic          rst_req,
  input logic          ext_clr
);

  // R2
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !tamper_flag);

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_flag && arm) |=> tamper_flag);

  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && clear_busy) |=> !rsp_valid);

  // R8
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(ram_locked)) |-> rsp_data == INVALID);

  // R10
  rst_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $rose(tamper_flag));

  // R11
  ext_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_clr) |-> ($rose(tamper_flag) && $past(clr_ext)));

  // R12
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

endmodule

bind tamper_guard tamper_guard_chk #(.DW(DW), .AW(AW), .INVALID(INVALID)) u_chk (.*);

// File: tb/tamper_guard_tb_top.sv
module tamper_guard_tb_top;

  localparam int RSTC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tamper_in = 1'b0, tick_1hz = 1'b0, osc_run = 1'b1, arm = 1'b0;
  logic polarity_open = 1'b0, sample_1hz = 1'b0, clr_ram = 1'b0, clr_ext = 1'b0;
  logic [1:0] clr_width = 2'd0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, tamper_flag, ram_locked, clear_busy, rst_req, ext_clr;
  logic [7:0] rsp_data;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tamper_guard #(.RST_CYCLES(RSTC)) dut_i (.*);

  // fields: open, sample, osc, pin, tick, expected flag
  localparam logic [5:0] VEC [8] = '{
    6'b0_0_1_1_0_1,  // R2 R3 closed, high -> event
    6'b0_0_1_0_0_0,  // R2 closed, low -> none
    6'b1_0_1_0_0_1,  // R2 open, low -> event
    6'b1_0_1_1_0_0,  // R2 open, high -> none
    6'b0_1_1_1_0_0,  // R4 sampling, no tick
    6'b0_1_1_1_1_1,  // R4 sampling, tick
    6'b0_1_0_1_0_1,  // R5 oscillator stopped
    6'b1_1_1_0_0_1   // R6 open ignores sampling
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic mem_write(input logic [6:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic mem_read(input logic [6:0] a, output logic [7:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    v = rsp_valid; d = rsp_data;
    req_valid = 1'b0;
  endtask

  task automatic disarm(input logic open_pol);
    arm = 1'b0;
    polarity_open = open_pol;
    tamper_in = open_pol;
    cyc(4);
  endtask

  initial begin
    #4_000_000;
    checks++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic v;
    int n;
    cyc(3);
    // R1 reset state
    chk(tamper_flag == 0 && ram_locked == 0 && clear_busy == 0, "R1 status", 0, 0);
    chk(rst_req == 0 && ext_clr == 0 && rsp_valid == 0, "R1 outputs", 0, 0);
    chk(req_ready == 1, "R1 ready", int'(req_ready), 1);
    rst_n = 1'b1;
    cyc(2);

    for (int k = 0; k < 8; k++) begin
      disarm(VEC[k][5]);
      sample_1hz = VEC[k][4];
      osc_run = VEC[k][3];
      arm = 1'b1;
      tamper_in = VEC[k][2];
      cyc(6);
      if (VEC[k][1]) pulse_tick();
      cyc(4);
      chk(tamper_flag == VEC[k][0], $sformatf("R2-table vec%0d (R4 R5 R6)", k),
          int'(tamper_flag), int'(VEC[k][0]));
    end

    // R3 sticky after pin returns idle
    disarm(1'b0);
    sample_1hz = 1'b0; osc_run = 1'b1; arm = 1'b1;
    tamper_in = 1'b1;
    cyc(2);
    chk(tamper_flag == 0, "R3 before third edge", int'(tamper_flag), 0);
    cyc(1);
    chk(tamper_flag == 1, "R3 third edge", int'(tamper_flag), 1);
    tamper_in = 1'b0;
    cyc(5);
    chk(tamper_flag == 1, "R3 sticky", int'(tamper_flag), 1);

    // R12 fill memory
    disarm(1'b0);
    for (int a = 0; a < 128; a++) mem_write(7'(a), 8'(a) ^ 8'h5A);
    mem_read(7'd5, d, v);
    chk(v == 1 && d == (8'd5 ^ 8'h5A), "R12 read", int'(d), int'(8'd5 ^ 8'h5A));
    mem_read(7'd127, d, v);
    chk(v == 1 && d == (8'd127 ^ 8'h5A), "R12 read top", int'(d), int'(8'd127 ^ 8'h5A));

    // R9 R10 R11: event without memory clear and without external pulse
    clr_ram = 1'b0; clr_ext = 1'b0; arm = 1'b1;
    tamper_in = 1'b1;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rst_req) n++;
      if (clear_busy || ext_clr) chk(1'b0, "R9 R11 no clear", 1, 0);
    end
    chk(n == RSTC, "R10 reset length", n, RSTC);
    chk(ram_locked == 0, "R9 not locked", int'(ram_locked), 0);
    mem_read(7'd5, d, v);
    chk(d == (8'd5 ^ 8'h5A), "R9 kept", int'(d), int'(8'd5 ^ 8'h5A));

    // R7 R8 R11: event with memory clear and 4-tick external pulse
    disarm(1'b0);
    clr_ram = 1'b1; clr_ext = 1'b1; clr_width = 2'd2; arm = 1'b1;
    tamper_in = 1'b1;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clear_busy) n++;
      if (clear_busy && req_ready) chk(1'b0, "R7 ready low", 1, 0);
    end
    chk(n == 128, "R7 busy length", n, 128);
    chk(ram_locked == 1, "R8 locked", int'(ram_locked), 1);
    mem_read(7'd3, d, v);
    chk(v == 1 && d == 8'hFF, "R8 invalid read", int'(d), 8'hFF);
    mem_write(7'd3, 8'h33);
    for (int t = 0; t < 4; t++) begin
      chk(ext_clr == 1, "R11 pulse held", int'(ext_clr), 1);
      pulse_tick();
    end
    chk(ext_clr == 0, "R11 pulse end code2", int'(ext_clr), 0);
    arm = 1'b0;
    cyc(2);
    chk(ram_locked == 0, "R8 unlock", int'(ram_locked), 0);
    mem_read(7'd3, d, v);
    chk(d == 8'h00, "R8 write dropped", int'(d), 0);
    mem_read(7'd0, d, v);
    chk(d == 8'h00, "R7 byte0 zero", int'(d), 0);
    mem_read(7'd127, d, v);
    chk(d == 8'h00, "R7 byte127 zero", int'(d), 0);

    // R11 shortest width
    disarm(1'b0);
    clr_ram = 1'b0; clr_ext = 1'b1; clr_width = 2'd0; arm = 1'b1;
    tamper_in = 1'b1;
    cyc(4);
    chk(ext_clr == 1, "R11 pulse start", int'(ext_clr), 1);
    pulse_tick();
    chk(ext_clr == 0, "R11 pulse end code0", int'(ext_clr), 0);

    finish_run();
  end

endmodule